// File: doc/BRIEF.md
# Clocked Serial Master Port with Status Register

This block is a serial master that moves one data word at a time over a three-wire link. It drives its own serial clock and shifts the word out on one line, most significant bit first. At the same time it collects a word from the input line. A processor controls it through four small registers: control, transmit data, receive data and status.

A transfer starts when the processor writes the transmit register. In receive-only use, a read of the receive register starts the transfer instead. At the end of each transfer the block raises one of two interrupt pulses, one for a normal completion and one for an error.

The status register reports two things: whether a transfer is in progress, and whether a received word was overwritten before the processor read it. The block has a single-shot mode and a continuous mode. In continuous mode, a transmit word queued during a transfer is sent right after it. The two modes also handle a lost receive word differently.

Top module: `sport_ctrl`

## Requirements
- R1: The register address `cpu_addr` selects one of four registers:
  - 0: control. Bit 0 is power, bit 1 is continuous mode, bit 2 is receive-only.
  - 1: transmit data.
  - 2: receive data.
  - 3: status. Bit 7 is busy, bit 0 is overrun, and bits 6..1 always read 0.

  A read returns its data on `cpu_rdata` one cycle after `cpu_rd`. After reset the status register reads 0x00.
- R2: When power is on and receive-only is 0, a write to the transmit register while idle starts a transfer of the written word. Busy is 1 from the next clock edge onward.
- R3: When receive-only is 1, a read of the receive register while idle starts a transfer, and a write to the transmit register starts nothing. A starting read also empties the receive buffer, so that read is never counted as an overrun.
- R4: The serial clock idles low and has a period of 2*HALF system clocks. Output data is MSB first and changes on the falling serial edges. Input is sampled on the rising edges. Each transfer has 8 rising edges, and the received word is the sampled bits in order, MSB first.
- R5: Busy clears on the last (16th) serial edge, which is a falling edge. At that same clock edge the received word is loaded into the receive register.
- R6: If a transfer is not an overrun, `irq_rx` is high for exactly one cycle at the clock edge that clears busy. That edge is 16*HALF clocks after the start edge.
- R7: A transfer that starts while the receive register still holds an unread word is an overrun. When it starts, the overrun flag becomes 1. When it ends, the new word replaces the old one.
- R8: At the end of an overrun transfer in continuous mode, `irq_err` pulses for one cycle and `irq_rx` stays low.
- R9: At the end of an overrun transfer in single mode, neither interrupt pulses.
- R10: Writing the status register with bit 0 = 0 clears the overrun flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R11: While power is 0, the status register reads 0x00, any running transfer is abandoned without an interrupt, and start requests are ignored.
- R12: A start request during a transfer works as follows:
  - In continuous mode, the queued transfer begins one cycle after the current one ends.
  - In single mode, the request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Registered read data |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive-complete pulse |
| irq_err | output | 1 | Receive-error pulse |

## Verification
The hardest case to reach is the continuous-mode overrun. The unread word and the next transfer's start are only one clock apart, so a processor can never read the receive register in between.

The bench reaches this case by writing a second transmit word while the first transfer is still running. The automatic restart then begins with the buffer still full. The bench checks that the error pulse replaces the completion pulse and that the receive register holds the second word.

A slave model clocked by `sck` returns a computed word for each transfer and records what it received. This lets the bench check every transmit value in a full sweep.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TXD  = 2'd1;
  localparam logic [1:0] A_RXD  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int C_PWR    = 0;
  localparam int C_CONT   = 1;
  localparam int C_RXONLY = 2;
  localparam int S_OVR    = 0;
endpackage

// File: rtl/sport_sclk_gen.sv
module sport_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic [DW-1:0] din,
  input  logic          sdi,
  output logic          busy,
  output logic          sck,
  output logic          sdo,
  output logic          fin,
  output logic [DW-1:0] rx_word
);
  localparam int NEDGE = 2 * DW;
  localparam int EW    = $clog2(NEDGE);
  localparam logic [EW-1:0] LAST = EW'(NEDGE - 1);

  logic          tick;
  logic [EW-1:0] ecnt;
  logic [DW-1:0] txs;
  logic [DW-1:0] rxs;
  logic          last;

  sport_sclk_gen #(.HALF(HALF)) u_gen (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  assign last = (ecnt == LAST);
  assign fin  = tick && last;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      sck  <= 1'b0;
      ecnt <= '0;
      txs  <= '0;
      rxs  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      sck  <= 1'b0;
      ecnt <= '0;
      txs  <= din;
    end else if (tick) begin
      ecnt <= ecnt + 1'b1;
      sck  <= ~sck;
      if (!sck) rxs <= {rxs[DW-2:0], sdi};
      else if (!last) txs <= {txs[DW-2:0], 1'b0};
      if (last) busy <= 1'b0;
    end
  end

  assign sdo     = txs[DW-1];
  assign rx_word = rxs;
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int DW   = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          sck,
  output logic          sdo,
  input  logic          sdi,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [2:0]    ctrl;
  logic [DW-1:0] txd;
  logic [DW-1:0] rxd;
  logic          pwr, cont, rxonly;
  logic          wr_tx, wr_ctrl, wr_stat, rd_rx;
  logic          trig, start;
  logic          sh_busy, fin;
  logic [DW-1:0] rx_word;
  logic          ovr, full, pend, ovr_xfer, done_q;

  assign pwr    = ctrl[C_PWR];
  assign cont   = ctrl[C_CONT];
  assign rxonly = ctrl[C_RXONLY];

  assign wr_ctrl = cpu_wr && (cpu_addr == A_CTRL);
  assign wr_tx   = cpu_wr && (cpu_addr == A_TXD);
  assign wr_stat = cpu_wr && (cpu_addr == A_STAT);
  assign rd_rx   = cpu_rd && (cpu_addr == A_RXD);

  assign trig  = pwr && ((wr_tx && !rxonly) || (rd_rx && rxonly));
  assign start = pwr && !sh_busy && (trig || (done_q && pend));

  sport_shifter #(.DW(DW), .HALF(HALF)) u_shift (
    .clk(clk), .rst(rst), .abort(!pwr), .start(start),
    .din(wr_tx ? cpu_wdata : txd), .sdi(sdi),
    .busy(sh_busy), .sck(sck), .sdo(sdo), .fin(fin), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      txd  <= '0;
      rxd  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= cpu_wdata[2:0];
      if (wr_tx) txd <= cpu_wdata;
      if (fin) rxd <= rx_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr) begin
      ovr      <= 1'b0;
      full     <= 1'b0;
      pend     <= 1'b0;
      ovr_xfer <= 1'b0;
      done_q   <= 1'b0;
      irq_rx   <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      done_q  <= fin;
      irq_rx  <= fin && !ovr_xfer;
      irq_err <= fin && ovr_xfer && cont;
      if (fin) full <= 1'b1;
      else if (rd_rx) full <= 1'b0;
      if (start) ovr_xfer <= full && !rd_rx;
      if (start && full && !rd_rx) ovr <= 1'b1;
      else if (wr_stat && !cpu_wdata[S_OVR]) ovr <= 1'b0;
      if (start) pend <= 1'b0;
      else if (trig && sh_busy && cont) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (cpu_rd) begin
      case (cpu_addr)
        A_CTRL:  cpu_rdata <= DW'(ctrl);
        A_TXD:   cpu_rdata <= txd;
        A_RXD:   cpu_rdata <= rxd;
        default: cpu_rdata <= {sh_busy, {(DW-2){1'b0}}, ovr};
      endcase
    end
  end
endmodule

// File: rtl/sport_ctrl_chk.sv
module sport_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [1:0]    cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          sck,
  input logic          irq_rx,
  input logic          irq_err,
  input logic          busy,
  input logic          ovr,
  input logic          pwr,
  input logic          cont,
  input logic          fin,
  input logic          start
);
  p_stat_pad_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 2'd3) |=> (cpu_rdata[DW-2:1] == '0));

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  p_end_clears_busy_r5: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);

  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    irq_rx |=> !irq_rx);

  p_single_irq_r8: assert property (@(posedge clk) disable iff (rst)
    !(irq_rx && irq_err));

  p_err_cont_only_r9: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(cont));

  p_ovr_w1_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 2'd3 && cpu_wdata[0] && !ovr && !start) |=> !ovr);

  p_pwr_off_r11: assert property (@(posedge clk) disable iff (rst)
    !pwr |=> (!busy && !ovr));
endmodule

bind sport_ctrl sport_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .sck(sck), .irq_rx(irq_rx), .irq_err(irq_err), .busy(sh_busy),
  .ovr(ovr), .pwr(pwr), .cont(cont), .fin(fin), .start(start)
);

// File: tb/sport_ctrl_test.sv
module sport_ctrl_test;
  localparam int HALF = 2;
  localparam int XCYC = 16 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic sck, sdo, sdi, irq_rx, irq_err;

  int vectors = 0, miscompares = 0, cyc = 0;
  int n_rx = 0, n_err = 0, rx_cyc = 0, t0 = 0;
  int nrise = 0, nfall = 0, ridx = 0, fidx = 0, sck_rises = 0;
  logic [7:0] cap = 8'd0, sout = 8'd0;
  logic [7:0] got [0:511];
  logic [7:0] rv;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sport_ctrl #(.DW(8), .HALF(HALF)) uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sck(sck), .sdo(sdo), .sdi(sdi), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  function automatic logic [7:0] slave_word(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign sdi = sout[7];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq_rx) begin n_rx++; rx_cyc = cyc; end
    if (irq_err) n_err++;
  end

  always @(posedge sck) begin
    cap = {cap[6:0], sdo};
    sck_rises++;
    nrise++;
    if (nrise == 8) begin got[ridx & 511] = cap; ridx++; nrise = 0; end
  end

  always @(negedge sck) begin
    nfall++;
    if (nfall == 8) begin nfall = 0; fidx++; sout = slave_word(fidx); end
    else sout = {sout[6:0], 1'b0};
  end

  task automatic slave_sync(input int i);
    nrise = 0; nfall = 0; ridx = i; fidx = i; sout = slave_word(i);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int base, nrx0, nerr0, sr0;
    idle(5);
    rst = 1'b0;
    idle(2);
    slave_sync(0);
    rd(2'd3, rv); chk("R1 status after reset", rv, 8'h00);
    chk("R4 sck idle low", sck, 0);
    chk("R6 no irq after reset", irq_rx | irq_err, 0);

    wr(2'd0, 8'h01);
    wr(2'd1, 8'hA5); t0 = cyc;
    rd(2'd3, rv); chk("R2 busy after tx write", rv, 8'h80);
    chk("R1 status pad bits", rv[6:1], 0);
    idle(XCYC + 4);
    chk("R6 irq_rx timing", rx_cyc, t0 + XCYC);
    chk("R6 irq_rx count", n_rx, 1);
    chk("R4 rising edges per transfer", sck_rises, 8);
    rd(2'd3, rv); chk("R5 busy cleared", rv, 8'h00);
    rd(2'd2, rv); chk("R5 rx word loaded", rv, slave_word(0));
    chk("R4 slave received tx word", got[0], 8'hA5);

    base = ridx;
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v));
      idle(XCYC + 3);
      rd(2'd2, rv);
      chk("R4 sweep rx word", rv, slave_word(base + v));
      chk("R4 sweep tx word", got[(base + v) & 511], v);
    end
    chk("R6 sweep irq count", n_rx, 257);
    chk("R9 no error irq in sweep", n_err, 0);

    wr(2'd3, 8'h01);
    rd(2'd3, rv); chk("R10 write 1 does not set overrun", rv, 8'h00);

    base = ridx; nrx0 = n_rx;
    wr(2'd1, 8'h3C); idle(XCYC + 3);
    wr(2'd1, 8'hC3);
    rd(2'd3, rv); chk("R7 overrun flag at start", rv, 8'h81);
    idle(XCYC + 3);
    chk("R9 no irq_rx on single overrun", n_rx, nrx0 + 1);
    chk("R9 no irq_err on single overrun", n_err, 0);
    rd(2'd2, rv); chk("R7 rx overwritten", rv, slave_word(base + 1));
    chk("R7 second word sent", got[(base + 1) & 511], 8'hC3);
    wr(2'd3, 8'h01);
    rd(2'd3, rv); chk("R10 write 1 keeps overrun", rv, 8'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, rv); chk("R10 write 0 clears overrun", rv, 8'h00);

    base = ridx; nrx0 = n_rx;
    wr(2'd1, 8'h11); idle(5);
    wr(2'd1, 8'h22); idle(2 * XCYC + 10);
    chk("R12 single mode ignores busy trigger", ridx, base + 1);
    chk("R12 single word sent", got[base & 511], 8'h11);
    chk("R12 one irq", n_rx, nrx0 + 1);
    rd(2'd2, rv);

    wr(2'd0, 8'h03);
    base = ridx; nrx0 = n_rx; nerr0 = n_err;
    wr(2'd1, 8'h5A); idle(5);
    wr(2'd1, 8'h6B); idle(2 * XCYC + 10);
    chk("R12 continuous restart count", ridx, base + 2);
    chk("R12 first word", got[base & 511], 8'h5A);
    chk("R12 queued word", got[(base + 1) & 511], 8'h6B);
    chk("R8 irq_rx for first", n_rx, nrx0 + 1);
    chk("R8 irq_err for overrun", n_err, nerr0 + 1);
    rd(2'd3, rv); chk("R8 overrun flag", rv, 8'h01);
    rd(2'd2, rv); chk("R8 rx overwritten", rv, slave_word(base + 1));
    wr(2'd3, 8'h00);

    wr(2'd0, 8'h05);
    base = ridx; nrx0 = n_rx;
    wr(2'd1, 8'h77);
    rd(2'd3, rv); chk("R3 tx write ignored in rx-only", rv, 8'h00);
    rd(2'd2, rv);
    rd(2'd3, rv); chk("R3 dummy read starts", rv, 8'h80);
    idle(XCYC + 3);
    rd(2'd2, rv); chk("R3 rx word", rv, slave_word(base));
    rd(2'd3, rv); chk("R3 restart not overrun", rv, 8'h80);
    idle(XCYC + 3);
    chk("R3 two completions", n_rx, nrx0 + 2);
    wr(2'd0, 8'h01);
    rd(2'd2, rv);

    nrx0 = n_rx; nerr0 = n_err;
    wr(2'd1, 8'h01); idle(XCYC + 3);
    wr(2'd1, 8'h02); idle(6);
    rd(2'd3, rv); chk("R7 overrun before power off", rv, 8'h81);
    wr(2'd0, 8'h00);
    rd(2'd3, rv); chk("R11 power off clears status", rv, 8'h00);
    idle(XCYC + 5);
    chk("R11 aborted no irq_rx", n_rx, nrx0 + 1);
    chk("R11 aborted no irq_err", n_err, nerr0);
    sr0 = sck_rises;
    wr(2'd1, 8'h99); idle(XCYC);
    chk("R11 no serial clock when off", sck_rises, sr0);
    rd(2'd3, rv); chk("R11 status stays zero", rv, 8'h00);
    wr(2'd0, 8'h01);
    slave_sync(400);
    wr(2'd1, 8'h42); idle(XCYC + 3);
    chk("R11 works after power on", got[400 & 511], 8'h42);
    rd(2'd2, rv); chk("R11 rx after power on", rv, slave_word(400));
    rd(2'd3, rv); chk("R11 no stale overrun", rv, 8'h00);

    summary();
  end
endmodule